// File: doc/BRIEF.md
# Alarm Status Flag Register

This block holds one sticky event flag per alarm and drives a single active-low interrupt line. Each alarm's comparator, which lives outside the block, sends a one-cycle match pulse when the current time equals that alarm's setting. The pulse latches the matching flag, and the flag stays set until software clears it. Software can clear a flag but can never set one.

Software reaches the block through a simple register bus with an address, a write strobe, write data and registered read data. There are two registers. The status register at address 0x0F holds the flags. The control register at address 0x0E holds one interrupt enable per alarm and a global interrupt-mode bit. The interrupt line is low while any flag is set whose enable is also set, provided the mode bit is 1. The line is a level, not a pulse.

Top module: `alarm_status_block`

## Requirements
- R1: After a synchronous reset, both flags and all control bits are 0, `irq_n` is 1, and reads of 0x0E and 0x0F return 0.
- R2: A 1 on `match_pulse[i]` at a clock edge sets flag i. Alarm 0's flag is status bit 0 and alarm 1's flag is status bit 1. The flag stays set until it is cleared.
- R3: A write to 0x0F with a 0 in data bit i clears flag i at that edge.
- R4: A write to 0x0F with a 1 in data bit i leaves flag i unchanged, so software cannot set a flag.
- R5: Status bits 7 through 2 always read 0 and ignore writes.
- R6: The control register at 0x0E is read/write. Bit 0 enables alarm 0, bit 1 enables alarm 1, bit 2 is the interrupt-mode bit, and bits 7 through 3 read 0.
- R7: `irq_n` is 0 in the cycle after an edge where the mode bit is 1 and some flag i is 1 with enable i also 1. Otherwise `irq_n` is 1.
- R8: If a match pulse and a clearing write hit the same flag at the same edge, the flag ends up set.
- R9: `bus_rdata` is registered. After an edge it shows the register selected by `bus_addr` at that edge, as it stood before the edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| match_pulse | input | 2 | Per-alarm time-match pulse |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
The bench writes all ones to the status register, both before and after a flag is set. A design that treated the flag as plain read/write would show a flag that software set or kept by accident.

It toggles each enable bit and the mode bit separately while a flag is held set. A missing gating term would pull `irq_n` low with the alarm disabled or in square-wave mode.

It drives a clearing write and a match pulse at the same edge. A design where the clear wins would read back 0 and silently lose the alarm. The bench also reads the upper status bits, the upper control bits and an unmapped address to catch any stray nonzero bits.

// File: rtl/alarm_status_pkg.sv
package alarm_status_pkg;
  localparam int unsigned NUM_ALARMS  = 2;
  localparam int unsigned BUS_DW      = 8;
  localparam int unsigned BUS_AW      = 8;
  localparam logic [7:0]  STATUS_ADDR = 8'h0F;
  localparam logic [7:0]  CONTROL_ADDR = 8'h0E;
endpackage

// File: rtl/alarm_flag_bit.sv
module alarm_flag_bit (
  input  logic clk,
  input  logic rst,
  input  logic hit,      // comparator match pulse
  input  logic wr_stat,  // write strobe decoded to the status register
  input  logic wr_bit,   // data bit for this flag
  output logic flag
);
  logic clr;
  assign clr = wr_stat && !wr_bit;

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;   // set has priority over clear
    else if (clr) flag <= 1'b0;
  end

  // R2 R8
  set_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);
  // R4
  no_sw_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag && !hit) |=> !flag);
  // R3
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !wr_bit && !hit) |=> !flag);
endmodule

// File: rtl/alarm_ctrl_reg.sv
module alarm_ctrl_reg #(
  parameter int unsigned N = 2,
  localparam int unsigned CW = N + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic [CW-1:0] wdata,
  output logic [N-1:0]  enables,
  output logic          mode
);
  logic [CW-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata;
  end

  assign enables = ctrl_q[N-1:0];
  assign mode    = ctrl_q[N];

  // R6
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> ({mode, enables} == $past(wdata)));
endmodule

// File: rtl/alarm_irq_gen.sv
module alarm_irq_gen #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  input  logic         mode,
  output logic         irq_n
);
  logic pending;
  assign pending = mode && (|(flags & enables));

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= !pending;
  end

  // R7
  irq_assert_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && (|(flags & enables))) |=> !irq_n);
  // R7
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode || !(|(flags & enables))) |=> irq_n);
endmodule

// File: rtl/alarm_status_block.sv
module alarm_status_block
  import alarm_status_pkg::*;
#(
  parameter int unsigned N  = NUM_ALARMS,
  parameter int unsigned DW = BUS_DW,
  parameter int unsigned AW = BUS_AW,
  parameter logic [AW-1:0] STAT_A = AW'(STATUS_ADDR),
  parameter logic [AW-1:0] CTRL_A = AW'(CONTROL_ADDR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [N-1:0]  match_pulse,
  output logic          irq_n
);
  localparam int unsigned CW = N + 1;

  logic          wr_stat, wr_ctrl;
  logic [N-1:0]  flags, enables;
  logic          mode;
  logic [DW-1:0] rd_mux;

  assign wr_stat = bus_we && (bus_addr == STAT_A);
  assign wr_ctrl = bus_we && (bus_addr == CTRL_A);

  for (genvar i = 0; i < N; i++) begin : g_flag
    alarm_flag_bit u_flag (
      .clk     (clk),
      .rst     (rst),
      .hit     (match_pulse[i]),
      .wr_stat (wr_stat),
      .wr_bit  (bus_wdata[i]),
      .flag    (flags[i])
    );
  end

  alarm_ctrl_reg #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_ctrl (wr_ctrl),
    .wdata   (bus_wdata[CW-1:0]),
    .enables (enables),
    .mode    (mode)
  );

  alarm_irq_gen #(.N(N)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .flags   (flags),
    .enables (enables),
    .mode    (mode),
    .irq_n   (irq_n)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == STAT_A)      rd_mux[N-1:0]  = flags;
    else if (bus_addr == CTRL_A) rd_mux[CW-1:0] = {mode, enables};
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  // R5
  stat_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == STAT_A) |=> (bus_rdata[DW-1:N] == '0));
  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != STAT_A && bus_addr != CTRL_A) |=> (bus_rdata == '0));
endmodule

// File: tb/sim_alarm_status_block.sv
module sim_alarm_status_block;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] match_pulse = '0;
  logic       irq_n;

  int vectors = 0;
  int miscompares = 0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb_q[$];
  logic rd_req = 1'b0;
  logic rd_issued = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  alarm_status_block u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .match_pulse(match_pulse), .irq_n(irq_n)
  );

  always @(posedge clk) rd_issued <= rd_req;

  // monitor: compare read data against the scoreboard
  always @(negedge clk) begin
    if (rd_issued && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      vectors++;
      if (bus_rdata !== e.exp) begin
        miscompares++;
        $display("FAIL %s: rdata=%h expected=%h", e.tag, bus_rdata, e.exp);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    bus_addr = a; rd_req = 1'b1;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic pulse(input logic [1:0] m);
    @(negedge clk);
    match_pulse = m;
    @(negedge clk);
    match_pulse = '0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);  // irq register follows state by one edge
    vectors++;
    if (irq_n !== exp) begin
      miscompares++;
      $display("FAIL %s: irq_n=%b expected=%b", tag, irq_n, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk_irq(1'b1, "R1 irq idle after reset");
    rd(8'h0F, 8'h00, "R1 status after reset");
    rd(8'h0E, 8'h00, "R1 control after reset");
    // R4 R5: software cannot set flags or upper bits
    wr(8'h0F, 8'hFF);
    rd(8'h0F, 8'h00, "R4 R5 write ones to cleared status");
    // R2
    pulse(2'b01);
    rd(8'h0F, 8'h01, "R2 alarm0 match sets bit0");
    chk_irq(1'b1, "R7 no irq with control zero");
    // R7 mode bit gating
    wr(8'h0E, 8'h03);
    chk_irq(1'b1, "R7 enables set but mode 0");
    rd(8'h0E, 8'h03, "R6 control readback");
    // R6 upper bits
    wr(8'h0E, 8'hFF);
    rd(8'h0E, 8'h07, "R6 control upper bits read 0");
    chk_irq(1'b0, "R7 irq asserted flag0 enabled");
    // R7 enable gating
    wr(8'h0E, 8'h06);
    chk_irq(1'b1, "R7 alarm0 enable off");
    rd(8'h0F, 8'h01, "R2 flag0 sticky");
    pulse(2'b10);
    rd(8'h0F, 8'h02 | 8'h01, "R2 alarm1 match sets bit1");
    chk_irq(1'b0, "R7 irq from alarm1");
    // R3 selective clear, R4 ones keep
    wr(8'h0F, 8'hFE);
    rd(8'h0F, 8'h02, "R3 clear bit0 only");
    wr(8'h0F, 8'hFF);
    rd(8'h0F, 8'h02, "R4 ones leave flag1 set");
    wr(8'h0F, 8'h00);
    rd(8'h0F, 8'h00, "R3 clear all");
    chk_irq(1'b1, "R7 irq released after clear");
    // R8 simultaneous set and clear
    @(negedge clk);
    bus_addr = 8'h0F; bus_wdata = 8'h00; bus_we = 1'b1; match_pulse = 2'b01;
    @(negedge clk);
    bus_we = 1'b0; match_pulse = '0;
    rd(8'h0F, 8'h01, "R8 set wins over clear");
    // R9 unmapped address
    rd(8'h05, 8'h00, "R9 unmapped reads zero");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule